// File: doc/BRIEF.md
# DMA Linked Descriptor Chain Sequencer

This block drives one DMA channel in linked-list mode. Software gives it the address of a first descriptor and pulses a start input. The engine then reads the descriptor, one 32-bit word at a time, over a single-access memory port. It checks the header flags and loads the transfer parameters into channel outputs. It starts an external data mover and waits for that mover to report completion.

After each transfer the engine can write the header back with its valid flag cleared. This marks the descriptor as consumed. It then either follows the descriptor's next pointer or ends the chain. When a chain ends, the engine can raise a one-cycle completion interrupt. The header's mask flag suppresses it. A chain that lands on a descriptor marked invalid ends without a transfer. A stop input abandons the chain once the memory access in flight has finished.

Each descriptor is eight consecutive words, four bytes apart:

| Word | Content |
|------|---------|
| 0 | Header |
| 1 | Source address |
| 2 | Destination address |
| 3 | Byte count |
| 4 | Channel configuration |
| 5 | Interval |
| 6 | Extension configuration |
| 7 | Next-descriptor address |

Top module: `dma_chain_seq`

## Requirements
- R1: After reset, busy_o, mem_req_o, xfer_start_o and irq_o are low, and cur_desc_o and last_hdr_o are zero.
- R2: A start_i pulse while idle latches start_addr_i. The engine then reads the descriptor words in ascending order at base+0, +4, ... +28. busy_o is high from the cycle after start_i until the engine returns to idle.
- R3: When xfer_start_o pulses, the channel outputs carry the descriptor's words in this order: src_addr_o (word 1), dst_addr_o (word 2), byte_cnt_o (word 3), chan_cfg_o (word 4), interval_o (word 5), chan_ext_o (word 6). The byte count carries all 32 bits, up to 0xFFFFFFFF.
- R4: xfer_start_o is a one-cycle pulse, issued only after all eight words are loaded. The engine then waits for xfer_done_i.
- R5: If header bit 2 is 0, the engine performs one write to the descriptor base address after xfer_done_i, with the header value and bit 0 cleared. If header bit 2 is 1, no write occurs.
- R6: If header bit 1 is 0, the engine next fetches the descriptor at the address held in word 7. If header bit 1 is 1, the chain ends after this transfer.
- R7: When a valid descriptor with bit 1 set finishes, irq_o pulses for exactly one cycle, unless header bit 3 is 1.
- R8: If a loaded header has bit 0 (valid) equal to 0, the engine does no transfer and reads no more words. irq_o pulses once if header bit 3 is 0, and the engine returns to idle.
- R9: A stop_i pulse during a chain ends it once the current memory access finishes. The aborted descriptor gets no write-back, and no interrupt is raised.
- R10: cur_desc_o gives the base address of the descriptor being processed, or the last one processed. last_hdr_o gives the last header word read.
- R11: A start_i pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| start_addr_i | input | AW | First descriptor address |
| stop_i | input | 1 | Abort request pulse |
| mem_req_o | output | 1 | Memory access request, held until acknowledged |
| mem_we_o | output | 1 | Write access when high |
| mem_addr_o | output | AW | Access byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access completes on req and ack |
| mem_rdata_i | input | 32 | Read data, valid with ack |
| xfer_start_o | output | 1 | Transfer start pulse to the data mover |
| xfer_done_i | input | 1 | Transfer finished pulse from the data mover |
| src_addr_o | output | AW | Source address |
| dst_addr_o | output | AW | Destination address |
| byte_cnt_o | output | 32 | Transfer byte count |
| chan_cfg_o | output | 32 | Channel configuration word |
| interval_o | output | 32 | Transfer interval word |
| chan_ext_o | output | 32 | Channel extension word |
| irq_o | output | 1 | Completion interrupt pulse |
| busy_o | output | 1 | Chain in progress |
| cur_desc_o | output | AW | Current descriptor base address |
| last_hdr_o | output | 32 | Last header read |

## Verification
The bench tries single descriptors with each useful combination of the four header flags. These show which flag controls the transfer, the write-back and the interrupt. The byte count includes the all-ones value. A three-descriptor chain with mixed write-back settings checks pointer following and the exact read-address order. A chain that lands on an invalid descriptor checks the early termination path. A stop during a stalled transfer and a start issued while busy check that neither disturbs memory or the interrupt.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned DESC_WORDS = 8;
  localparam int unsigned IDX_W      = $clog2(DESC_WORDS);

  // header flag positions
  localparam int unsigned HB_VALID = 0;
  localparam int unsigned HB_END   = 1;
  localparam int unsigned HB_NOWB  = 2;
  localparam int unsigned HB_MASK  = 3;

  // word slots inside a descriptor
  localparam int unsigned W_HDR  = 0;
  localparam int unsigned W_SRC  = 1;
  localparam int unsigned W_DST  = 2;
  localparam int unsigned W_LEN  = 3;
  localparam int unsigned W_CFG  = 4;
  localparam int unsigned W_ITV  = 5;
  localparam int unsigned W_EXT  = 6;
  localparam int unsigned W_NEXT = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_KICK, ST_WAIT, ST_WB, ST_NEXT
  } state_e;
endpackage

// File: rtl/dma_desc_regs.sv
module dma_desc_regs
  import dma_chain_pkg::*;
(
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                load_i,
  input  logic [IDX_W-1:0]                    idx_i,
  input  logic [WORD_W-1:0]                   data_i,
  output logic [DESC_WORDS-1:0][WORD_W-1:0]   words_o
);
  for (genvar w = 0; w < DESC_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  words_o[w] <= '0;
      else if (load_i && idx_i == IDX_W'(w))        words_o[w] <= data_i;
    end
  end
endmodule

// File: rtl/dma_chain_fsm.sv
module dma_chain_fsm
  import dma_chain_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     start_addr_i,
  input  logic              stop_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic [WORD_W-1:0] hdr_i,
  input  logic [AW-1:0]     next_i,
  output logic              load_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              xfer_start_o,
  input  logic              xfer_done_i,
  output logic              irq_o,
  output logic              busy_o,
  output logic [AW-1:0]     cur_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  state_e            st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [AW-1:0]     cur_q;
  logic              abort_q, irq_q;
  logic              abort;

  assign abort = stop_i | abort_q;

  always_comb begin
    mem_req_o    = (st_q == ST_FETCH) || (st_q == ST_WB);
    mem_we_o     = (st_q == ST_WB);
    mem_addr_o   = (st_q == ST_WB) ? cur_q : cur_q + AW'({idx_q, 2'b00});
    mem_wdata_o  = hdr_i & ~(WORD_W'(1) << HB_VALID);
    load_o       = (st_q == ST_FETCH) && mem_ack_i;
    idx_o        = idx_q;
    xfer_start_o = (st_q == ST_KICK);
    busy_o       = (st_q != ST_IDLE);
    irq_o        = irq_q;
    cur_o        = cur_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      cur_q   <= '0;
      abort_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (stop_i) abort_q <= 1'b1;
      unique case (st_q)
        ST_IDLE: begin
          abort_q <= 1'b0;
          if (start_i) begin
            cur_q <= start_addr_i;
            idx_q <= '0;
            st_q  <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_ack_i) begin
          if (abort) st_q <= ST_IDLE;
          else if (idx_q == '0 && !mem_rdata_i[HB_VALID]) begin
            irq_q <= !mem_rdata_i[HB_MASK];
            st_q  <= ST_IDLE;
          end else if (idx_q == LAST_IDX) st_q <= ST_KICK;
          else idx_q <= idx_q + 1'b1;
        end
        ST_KICK: st_q <= ST_WAIT;
        ST_WAIT: begin
          if (abort) st_q <= ST_IDLE;
          else if (xfer_done_i) st_q <= hdr_i[HB_NOWB] ? ST_NEXT : ST_WB;
        end
        ST_WB: if (mem_ack_i) st_q <= abort ? ST_IDLE : ST_NEXT;
        ST_NEXT: begin
          if (abort) st_q <= ST_IDLE;
          else if (hdr_i[HB_END]) begin
            irq_q <= !hdr_i[HB_MASK];
            st_q  <= ST_IDLE;
          end else begin
            cur_q <= next_i;
            idx_q <= '0;
            st_q  <= ST_FETCH;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     start_addr_i,
  input  logic              stop_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              xfer_start_o,
  input  logic              xfer_done_i,
  output logic [AW-1:0]     src_addr_o,
  output logic [AW-1:0]     dst_addr_o,
  output logic [31:0]       byte_cnt_o,
  output logic [31:0]       chan_cfg_o,
  output logic [31:0]       interval_o,
  output logic [31:0]       chan_ext_o,
  output logic              irq_o,
  output logic              busy_o,
  output logic [AW-1:0]     cur_desc_o,
  output logic [31:0]       last_hdr_o
);
  logic [DESC_WORDS-1:0][WORD_W-1:0] words;
  logic                              load;
  logic [IDX_W-1:0]                  idx;

  dma_desc_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .idx_i   (idx),
    .data_i  (mem_rdata_i),
    .words_o (words)
  );

  dma_chain_fsm #(.AW(AW)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .stop_i       (stop_i),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ack_i    (mem_ack_i),
    .mem_rdata_i  (mem_rdata_i),
    .hdr_i        (words[W_HDR]),
    .next_i       (words[W_NEXT][AW-1:0]),
    .load_o       (load),
    .idx_o        (idx),
    .xfer_start_o (xfer_start_o),
    .xfer_done_i  (xfer_done_i),
    .irq_o        (irq_o),
    .busy_o       (busy_o),
    .cur_o        (cur_desc_o)
  );

  assign src_addr_o = words[W_SRC][AW-1:0];
  assign dst_addr_o = words[W_DST][AW-1:0];
  assign byte_cnt_o = words[W_LEN];
  assign chan_cfg_o = words[W_CFG];
  assign interval_o = words[W_ITV];
  assign chan_ext_o = words[W_EXT];
  assign last_hdr_o = words[W_HDR];
endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_ack_i,
  input logic          xfer_start_o,
  input logic          irq_o,
  input logic          busy_o,
  input logic [AW-1:0] cur_desc_o,
  input logic [31:0]   last_hdr_o
);
  // R1
  req_needs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  // R4
  kick_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |=> !xfer_start_o);
  // R8
  kick_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |-> last_hdr_o[0]);
  // R5
  wb_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (!mem_wdata_o[0] && mem_addr_o == cur_desc_o && !last_hdr_o[2]));
  // R7
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

bind dma_chain_seq dma_chain_seq_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_ack_i    (mem_ack_i),
  .xfer_start_o (xfer_start_o),
  .irq_o        (irq_o),
  .busy_o       (busy_o),
  .cur_desc_o   (cur_desc_o),
  .last_hdr_o   (last_hdr_o)
);

// File: tb/dma_chain_seq_bench.sv
module dma_chain_seq_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned AW = 32;
  localparam int unsigned NV = 7;
  // header flags (bit3 mask, bit2 no-wb, bit1 end, bit0 valid)
  localparam logic [3:0]  V_HDR [NV] = '{4'b0011, 4'b0111, 4'b1011, 4'b0000, 4'b1000, 4'b1111, 4'b0010};
  localparam logic [31:0] V_LEN [NV] = '{32'h40, 32'h1, 32'h800, 32'h10, 32'h20, 32'hFFFF_FFFF, 32'h4};
  // expected {kick, write-back, irq}
  localparam logic [2:0]  V_EXP [NV] = '{3'b111, 3'b101, 3'b110, 3'b001, 3'b000, 3'b100, 3'b001};

  logic clk = 0, rst_n = 0;
  logic start = 0, stop = 0, ack = 0, done = 0;
  logic [AW-1:0] start_addr = '0;
  logic [31:0] rdata = '0;
  logic mem_req, mem_we, kick, irq, busy;
  logic [AW-1:0] mem_addr, src_a, dst_a, cur_desc;
  logic [31:0] wdata, cnt, cfg, itv, ext, last_hdr;

  dma_chain_seq #(.AW(AW)) u_dma_chain_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(start_addr), .stop_i(stop),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(wdata),
    .mem_ack_i(ack), .mem_rdata_i(rdata), .xfer_start_o(kick), .xfer_done_i(done),
    .src_addr_o(src_a), .dst_addr_o(dst_a), .byte_cnt_o(cnt), .chan_cfg_o(cfg),
    .interval_o(itv), .chan_ext_o(ext), .irq_o(irq), .busy_o(busy),
    .cur_desc_o(cur_desc), .last_hdr_o(last_hdr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] mem [0:255];
  logic [31:0] rd_log [0:63];
  logic [31:0] wr_a [0:15];
  logic [31:0] wr_d [0:15];
  int rd_n, wr_n, kicks, irqs, pw_err, done_cnt;
  logic done_hold = 0, kick_p = 0, irq_p = 0;
  logic [31:0] snap [6];

  // memory, data mover and pulse monitors, all on the falling edge
  always @(negedge clk) begin
    cycles++;
    if (mem_req && !ack) begin
      ack = 1;
      if (mem_we) begin
        mem[mem_addr[9:2]] = wdata;
        if (wr_n < 16) begin wr_a[wr_n] = mem_addr; wr_d[wr_n] = wdata; end
        wr_n++;
      end else begin
        rdata = mem[mem_addr[9:2]];
        if (rd_n < 64) rd_log[rd_n] = mem_addr;
        rd_n++;
      end
    end else ack = 0;
    done = 0;
    if (kick) begin
      kicks++; done_cnt = 3;
      snap[0] = src_a; snap[1] = dst_a; snap[2] = cnt;
      snap[3] = cfg;   snap[4] = itv;   snap[5] = ext;
    end else if (done_cnt != 0 && !done_hold) begin
      done_cnt--;
      if (done_cnt == 0) done = 1;
    end
    if (irq) irqs++;
    if ((kick && kick_p) || (irq && irq_p)) pw_err++;
    kick_p = kick; irq_p = irq;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    rd_n = 0; wr_n = 0; kicks = 0; irqs = 0; done_cnt = 0;
  endtask

  task automatic put_desc(input logic [31:0] base, hdr, s, d, l, c, i, e, n);
    mem[base[9:2]]   = hdr; mem[base[9:2]+1] = s; mem[base[9:2]+2] = d;
    mem[base[9:2]+3] = l;   mem[base[9:2]+4] = c; mem[base[9:2]+5] = i;
    mem[base[9:2]+6] = e;   mem[base[9:2]+7] = n;
  endtask

  task automatic pulse_start(input logic [31:0] a);
    @(negedge clk); start = 1; start_addr = a;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 2000 && busy; g++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = '0;
    clear_logs(); pw_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !mem_req && !kick && !irq, "R1", "idle outputs", {busy, mem_req, kick, irq}, 0);
    chk(cur_desc == 0 && last_hdr == 0, "R1", "status zero", cur_desc, 0);

    // single-descriptor table
    for (int v = 0; v < NV; v++) begin
      logic [31:0] h;
      h = {28'h0, V_HDR[v]};
      put_desc(32'h100, h, 32'h1000 + v*16, 32'h2000 + v, V_LEN[v], 32'hC0 + v,
               32'h10 + v, 32'hE0 + v, 32'h300);
      clear_logs();
      @(negedge clk); start = 1; start_addr = 32'h100;
      @(negedge clk); start = 0;
      chk(busy, "R2", "busy after start", busy, 1);
      wait_idle();
      chk(!busy, "R2", "idle at end", busy, 0);
      chk(kicks == int'(V_EXP[v][2]), V_EXP[v][2] ? "R4" : "R8", "kick count", kicks, V_EXP[v][2]);
      chk(wr_n == int'(V_EXP[v][1]), "R5", "write-back count", wr_n, V_EXP[v][1]);
      chk(irqs == int'(V_EXP[v][0]), V_HDR[v][0] ? "R7" : "R8", "irq count", irqs, V_EXP[v][0]);
      chk(rd_n == (V_HDR[v][0] ? 8 : 1), "R8", "read count", rd_n, V_HDR[v][0] ? 8 : 1);
      chk(rd_log[0] == 32'h100, "R2", "first read addr", rd_log[0], 32'h100);
      chk(last_hdr == h, "R10", "last header", last_hdr, h);
      if (V_EXP[v][1]) begin
        chk(wr_a[0] == 32'h100 && wr_d[0] == (h & ~32'h1), "R5", "write-back data", wr_d[0], h & ~32'h1);
        chk(mem[64] == (h & ~32'h1), "R5", "memory header cleared", mem[64], h & ~32'h1);
      end
      if (V_EXP[v][2]) begin
        chk(snap[0] == 32'h1000 + v*16 && snap[1] == 32'h2000 + v, "R3", "src/dst", snap[0], 32'h1000 + v*16);
        chk(snap[2] == V_LEN[v], "R3", "byte count", snap[2], V_LEN[v]);
        chk(snap[3] == 32'hC0 + v && snap[4] == 32'h10 + v && snap[5] == 32'hE0 + v,
            "R3", "cfg/itv/ext", snap[3], 32'hC0 + v);
      end
    end

    // R6 three-descriptor chain
    put_desc(32'h100, 32'h1, 32'hA1, 32'hB1, 32'h10, 0, 0, 0, 32'h200);
    put_desc(32'h200, 32'h5, 32'hA2, 32'hB2, 32'h20, 0, 0, 0, 32'h300);
    put_desc(32'h300, 32'h3, 32'hA3, 32'hB3, 32'h30, 0, 0, 0, 32'h0);
    clear_logs();
    pulse_start(32'h100);
    wait_idle();
    chk(kicks == 3, "R6", "chain kicks", kicks, 3);
    chk(rd_n == 24, "R6", "chain reads", rd_n, 24);
    begin
      int bad;
      bad = 0;
      for (int k = 0; k < 24; k++)
        if (rd_log[k] != (32'h100 * (k/8 + 1)) + 4*(k%8)) bad++;
      chk(bad == 0, "R2", "ascending fetch order", bad, 0);
    end
    chk(wr_n == 2 && wr_a[0] == 32'h100 && wr_a[1] == 32'h300, "R5", "chain write-backs", wr_n, 2);
    chk(mem[128] == 32'h5, "R5", "no-wb header kept", mem[128], 32'h5);
    chk(irqs == 1, "R7", "chain irq once", irqs, 1);
    chk(cur_desc == 32'h300 && last_hdr == 32'h3, "R10", "chain status", cur_desc, 32'h300);
    chk(snap[0] == 32'hA3 && snap[2] == 32'h30, "R3", "last transfer fields", snap[0], 32'hA3);

    // R8 chain lands on an invalid descriptor
    put_desc(32'h100, 32'h1, 32'hA1, 32'hB1, 32'h10, 0, 0, 0, 32'h380);
    put_desc(32'h380, 32'h0, 0, 0, 0, 0, 0, 0, 0);
    clear_logs();
    pulse_start(32'h100);
    wait_idle();
    chk(kicks == 1 && rd_n == 9, "R8", "invalid landing reads", rd_n, 9);
    chk(irqs == 1, "R8", "invalid landing irq", irqs, 1);
    chk(cur_desc == 32'h380 && last_hdr == 0, "R10", "invalid landing status", cur_desc, 32'h380);

    // R9 stop while the transfer is stalled
    put_desc(32'h100, 32'h3, 32'hA1, 32'hB1, 32'h10, 0, 0, 0, 0);
    clear_logs(); done_hold = 1;
    pulse_start(32'h100);
    for (int g = 0; g < 100 && kicks == 0; g++) @(negedge clk);
    repeat (4) @(negedge clk);
    stop = 1; @(negedge clk); stop = 0;
    wait_idle();
    done_hold = 0; done_cnt = 0;
    repeat (5) @(negedge clk);
    chk(!busy, "R9", "idle after stop", busy, 0);
    chk(wr_n == 0 && mem[64] == 32'h3, "R9", "no write-back on abort", wr_n, 0);
    chk(irqs == 0, "R9", "no irq on abort", irqs, 0);

    // R11 start while busy
    put_desc(32'h100, 32'h3, 32'hA1, 32'hB1, 32'h10, 0, 0, 0, 0);
    put_desc(32'h200, 32'h3, 32'hA2, 32'hB2, 32'h20, 0, 0, 0, 0);
    clear_logs(); done_hold = 1;
    pulse_start(32'h100);
    for (int g = 0; g < 100 && kicks == 0; g++) @(negedge clk);
    pulse_start(32'h200);
    done_hold = 0;
    wait_idle();
    chk(kicks == 1 && rd_n == 8, "R11", "second start ignored", rd_n, 8);
    chk(cur_desc == 32'h100 && snap[0] == 32'hA1, "R11", "kept first chain", cur_desc, 32'h100);
    chk(mem[128] == 32'h3, "R11", "other descriptor untouched", mem[128], 32'h3);

    chk(pw_err == 0, "R4", "kick/irq single-cycle pulses", pw_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    checks++; fails++;
    $display("FAIL watchdog act=%0d exp=0", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule